// File: doc/BRIEF.md
# User-Mode Instruction Trap Unit

This unit sits beside the instruction decoder of a 12-bit accumulator CPU. On every cycle in which the decoder presents an instruction, it decides whether that instruction must be handed to the supervisor instead of being carried out. That happens when the processor runs a user program and the time-sharing option is switched on. Three classes are privileged: every I/O transfer, the halt micro-operation, and any read of the front-panel switches.

When a privileged instruction arrives under those conditions, the unit does two things. It raises a one-cycle pulse that tells the CPU not to execute the instruction. It also sets a sticky trap flag, which the interrupt logic turns into a user-mode interrupt. The flag stays set until one of three things clears it: the front-panel clear switch, or one of the two flag-clearing I/O instructions issued by the supervisor (with the user flag clear).

Reset is asynchronous and active-low, and its release is synchronised to the clock through a configurable number of flip-flops.

Top module: `utrap_unit`

## Requirements
- R1: While `rst_n` is low, and for `SYNC_STAGES` rising clock edges after it rises, `trap_flag` and `suppress` are both 0, whatever the other inputs do. Taking `rst_n` low clears `trap_flag` without waiting for a clock edge.
- R2: An I/O transfer is an instruction whose bits [11:9] equal octal 6. If one is strobed by `dec_valid` while `user_mode` and `ts_enable` are both 1, `trap_flag` is 1 after the next rising edge.
- R3: A halt is an instruction with bits [11:9] = octal 7, bit 8 = 1, bit 0 = 0 and bit 1 = 1 (for example octal 7402 or 7412). Strobed in user mode with time-sharing enabled, it sets `trap_flag` at the next edge.
- R4: A switch read is an instruction with bits [11:9] = octal 7, bit 8 = 1, bit 0 = 0 and bit 2 = 1 (for example octal 7404, 7604 or 7406). Strobed in user mode with time-sharing enabled, it sets `trap_flag` at the next edge.
- R5: No trap occurs in the following cases: `dec_valid` is 0; `user_mode` is 0; `ts_enable` is 0; the instruction is neither an I/O transfer nor a halt or switch read of the group defined in R3. Instructions with bit 8 = 0 (such as 7002) and with bit 0 = 1 (such as 7403) are outside that group.
- R6: `panel_clear` high at a rising edge leaves `trap_flag` at 0 after that edge. This holds even when a trapping instruction is strobed in the same cycle.
- R7: Octal 6007 strobed with `user_mode` = 0 clears `trap_flag` at the next edge, whatever `ts_enable` is. Strobed with `user_mode` = 1, it does not clear the flag.
- R8: Octal 6204 strobed with `user_mode` = 0 clears `trap_flag` at the next edge, whatever `ts_enable` is.
- R9: Octal 6007 and 6204 strobed with `user_mode` = 1 and `ts_enable` = 1 are trapped like any other I/O transfer. They set `trap_flag` and pulse `suppress`.
- R10: In a cycle with no set and no clear condition, `trap_flag` keeps its value. Examples are no strobe, a non-privileged instruction, or an I/O transfer other than 6007 or 6204 with `user_mode` = 0.
- R11: `suppress` is 1 during exactly those cycles in which a trapping instruction (R2 to R4, R9) is strobed, and 0 in every other cycle. This includes a cycle that also has `panel_clear` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is being decoded this cycle |
| instr | input | 12 | Instruction word being decoded |
| user_mode | input | 1 | Processor is running a user program |
| ts_enable | input | 1 | Time-sharing option is enabled |
| panel_clear | input | 1 | Front-panel clear switch |
| trap_flag | output | 1 | Sticky user-mode trap request |
| suppress | output | 1 | Do not execute the current instruction |

## Verification
The bench builds the unit with `SYNC_STAGES` = 3 instead of the default 2. This makes the reset-release window long enough to drive a trapping instruction into it for two full cycles and see that neither output reacts. The 12-bit instruction width is fixed by the encoding. Every decode boundary is therefore reachable with concrete octal words: group selector bit 8, group-3 bit 0, and the exact 6007 and 6204 matches. Combinations of mode, enable and clear that happen in the same cycle are placed directly in the vector table.

// File: rtl/utrap_pkg.sv
package utrap_pkg;

  // Instruction word geometry
  localparam int INSTR_W  = 12;
  localparam int MAJOR_W  = 3;
  localparam int MAJOR_LO = INSTR_W - MAJOR_W;

  // Major opcode values in bits [11:9]
  localparam logic [MAJOR_W-1:0] MAJOR_IOT = 3'o6;
  localparam logic [MAJOR_W-1:0] MAJOR_OPR = 3'o7;

  // Operate-group bit positions (LSB = 0)
  localparam int GRP_SEL_BIT = 8;  // 1 selects group 2/3
  localparam int GRP3_BIT    = 0;  // 1 selects group 3
  localparam int HLT_BIT     = 1;
  localparam int OSR_BIT     = 2;

  // Supervisor flag-clearing I/O transfers
  localparam logic [INSTR_W-1:0] CLR_ALL_CODE  = 12'o6007;
  localparam logic [INSTR_W-1:0] CLR_UINT_CODE = 12'o6204;

  typedef struct packed {
    logic io_xfer;
    logic halt;
    logic sw_read;
    logic clr_all;
    logic clr_uint;
  } instr_class_t;

  typedef enum logic [1:0] {
    FLAG_HOLD = 2'd0,
    FLAG_CLR  = 2'd1,
    FLAG_SET  = 2'd2
  } flag_op_e;

endpackage

// File: rtl/utrap_rst_sync.sv
module utrap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/utrap_decode.sv
module utrap_decode
  import utrap_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output instr_class_t       cls
);

  logic [MAJOR_W-1:0] major;
  logic               is_opr;
  logic               opr_grp2;

  always_comb begin
    major    = instr[INSTR_W-1:MAJOR_LO];
    is_opr   = (major == MAJOR_OPR);
    // Group 2 micro-ops: selector set, group-3 marker clear
    opr_grp2 = is_opr && instr[GRP_SEL_BIT] && !instr[GRP3_BIT];

    cls.io_xfer  = (major == MAJOR_IOT);
    cls.halt     = opr_grp2 && instr[HLT_BIT];
    cls.sw_read  = opr_grp2 && instr[OSR_BIT];
    cls.clr_all  = (instr == CLR_ALL_CODE);
    cls.clr_uint = (instr == CLR_UINT_CODE);
  end

endmodule

// File: rtl/utrap_policy.sv
module utrap_policy
  import utrap_pkg::*;
(
  input  logic         dec_valid,
  input  instr_class_t cls,
  input  logic         user_mode,
  input  logic         ts_enable,
  input  logic         panel_clear,
  output flag_op_e     flag_op,
  output logic         trap_hit
);

  logic privileged;
  logic virt_on;
  logic clr_hit;

  always_comb begin
    privileged = cls.io_xfer || cls.halt || cls.sw_read;
    virt_on    = user_mode && ts_enable;
    trap_hit   = dec_valid && virt_on && privileged;
    clr_hit    = dec_valid && !user_mode && (cls.clr_all || cls.clr_uint);

    // Panel switch outranks everything; set and instruction clear are exclusive
    if (panel_clear) begin
      flag_op = FLAG_CLR;
    end else if (trap_hit) begin
      flag_op = FLAG_SET;
    end else if (clr_hit) begin
      flag_op = FLAG_CLR;
    end else begin
      flag_op = FLAG_HOLD;
    end
  end

endmodule

// File: rtl/utrap_flag.sv
module utrap_flag
  import utrap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  flag_op_e flag_op,
  output logic     flag_q
);

  logic flag_en;
  logic flag_d;

  always_comb begin
    flag_en = (flag_op != FLAG_HOLD);
    flag_d  = (flag_op == FLAG_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/utrap_unit.sv
module utrap_unit
  import utrap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               user_mode,
  input  logic               ts_enable,
  input  logic               panel_clear,
  output logic               trap_flag,
  output logic               suppress
);

  logic         rst_sync_n;
  instr_class_t cls;
  flag_op_e     flag_op;
  logic         trap_hit;

  utrap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  utrap_decode u_decode (
    .instr (instr),
    .cls   (cls)
  );

  utrap_policy u_policy (
    .dec_valid   (dec_valid),
    .cls         (cls),
    .user_mode   (user_mode),
    .ts_enable   (ts_enable),
    .panel_clear (panel_clear),
    .flag_op     (flag_op),
    .trap_hit    (trap_hit)
  );

  utrap_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flag_op (flag_op),
    .flag_q  (trap_flag)
  );

  // Pulse only in the decode cycle, and never while reset is held
  assign suppress = trap_hit && rst_sync_n;

endmodule

// File: rtl/utrap_chk.sv
module utrap_chk
  import utrap_pkg::*;
(
  input logic               clk,
  input logic               rst_sync_n,
  input logic               dec_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               user_mode,
  input logic               ts_enable,
  input logic               panel_clear,
  input logic               trap_flag,
  input logic               suppress
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!trap_flag && !suppress));

  // R2
  iot_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && user_mode && ts_enable && !panel_clear &&
     instr[INSTR_W-1:MAJOR_LO] == MAJOR_IOT) |=> trap_flag);

  // R6
  panel_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    panel_clear |=> !trap_flag);

  // R7
  clr_all_kernel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && !user_mode && instr == CLR_ALL_CODE) |=> !trap_flag);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!dec_valid && !panel_clear) |=> $stable(trap_flag));

  // R11
  suppress_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    suppress |-> (dec_valid && user_mode && ts_enable));

  // R11
  suppress_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (suppress && !panel_clear) |=> trap_flag);

endmodule

bind utrap_unit utrap_chk u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .dec_valid   (dec_valid),
  .instr       (instr),
  .user_mode   (user_mode),
  .ts_enable   (ts_enable),
  .panel_clear (panel_clear),
  .trap_flag   (trap_flag),
  .suppress    (suppress)
);

// File: tb/test_utrap_unit.sv
module test_utrap_unit;

  logic        clk;
  logic        rst_n;
  logic        dec_valid;
  logic [11:0] instr;
  logic        user_mode;
  logic        ts_enable;
  logic        panel_clear;
  logic        trap_flag;
  logic        suppress;

  int  n_chk;
  int  n_bad;
  bit  done;

  utrap_unit #(.SYNC_STAGES(3)) i_utrap_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .instr       (instr),
    .user_mode   (user_mode),
    .ts_enable   (ts_enable),
    .panel_clear (panel_clear),
    .trap_flag   (trap_flag),
    .suppress    (suppress)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {valid, user, ts, clear, instr[11:0], exp_suppress, exp_flag_after, req[3:0]}
  localparam int NV = 24;
  localparam logic [21:0] VEC [NV] = '{
    {4'b0110, 12'o6000, 2'b00, 4'd5},   // R5 no strobe
    {4'b1010, 12'o6031, 2'b00, 4'd5},   // R5 user flag clear
    {4'b1100, 12'o6031, 2'b00, 4'd5},   // R5 time-sharing off
    {4'b1110, 12'o1234, 2'b00, 4'd5},   // R5 memory reference
    {4'b1110, 12'o7002, 2'b00, 4'd5},   // R5 group 1 operate
    {4'b1110, 12'o7403, 2'b00, 4'd5},   // R5 group 3 operate
    {4'b1110, 12'o6031, 2'b11, 4'd2},   // R2 I/O transfer traps
    {4'b1110, 12'o1234, 2'b01, 4'd10},  // R10 hold
    {4'b0000, 12'o0000, 2'b01, 4'd10},  // R10 idle hold
    {4'b1000, 12'o6007, 2'b00, 4'd7},   // R7 clear-all in kernel
    {4'b1110, 12'o7402, 2'b11, 4'd3},   // R3 halt
    {4'b0001, 12'o0000, 2'b00, 4'd6},   // R6 panel clear
    {4'b1110, 12'o7604, 2'b11, 4'd4},   // R4 load from switches
    {4'b1010, 12'o6204, 2'b00, 4'd8},   // R8 clear user interrupt
    {4'b1110, 12'o7404, 2'b11, 4'd4},   // R4 OR switches
    {4'b1111, 12'o6031, 2'b10, 4'd6},   // R6 clear beats set; R11 pulse still
    {4'b1110, 12'o6007, 2'b11, 4'd9},   // R9 clear-all trapped
    {4'b1110, 12'o6204, 2'b11, 4'd9},   // R9 clear-uint trapped
    {4'b1100, 12'o6007, 2'b01, 4'd7},   // R7 no clear with user flag set
    {4'b1010, 12'o6205, 2'b01, 4'd10},  // R10 other I/O in kernel
    {4'b1110, 12'o7412, 2'b11, 4'd3},   // R3 halt with other bits
    {4'b0001, 12'o0000, 2'b00, 4'd6},   // R6 panel clear
    {4'b1110, 12'o7406, 2'b11, 4'd4},   // R4 OSR plus halt
    {4'b1000, 12'o6204, 2'b00, 4'd8}    // R8 with ts off
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic u, input logic t,
                       input logic c, input logic [11:0] w);
    dec_valid   = v;
    user_mode   = u;
    ts_enable   = t;
    panel_clear = c;
    instr       = w;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 12'o0);

    // R1 reset state, with a trapping instruction presented
    repeat (2) @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 12'o6031);
    @(negedge clk);
    chk("R1 flag in reset", trap_flag, 1'b0);
    chk("R1 suppress in reset", suppress, 1'b0);
    rst_n = 1'b1;
    // R1 release window: two edges inside SYNC_STAGES=3
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R1 flag in release window", trap_flag, 1'b0);
      chk("R1 suppress in release window", suppress, 1'b0);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 12'o0);
    repeat (3) @(negedge clk);
    chk("R1 flag after release", trap_flag, 1'b0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k][21], VEC[k][20], VEC[k][19], VEC[k][18], VEC[k][17:6]);
      #5;
      chk($sformatf("R%0d/R11 suppress vec %0d", VEC[k][3:0], k), suppress, VEC[k][5]);
      @(posedge clk);
      #1;
      chk($sformatf("R%0d flag vec %0d", VEC[k][3:0], k), trap_flag, VEC[k][4]);
    end

    // R11 back-to-back trapped instructions, then idle
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 12'o6031);
    #5 chk("R11 suppress first", suppress, 1'b1);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 12'o7402);
    #5 chk("R11 suppress second", suppress, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 12'o7402);
    #5 chk("R11 suppress drops without strobe", suppress, 1'b0);
    chk("R2 flag after trap burst", trap_flag, 1'b1);

    // R1 asynchronous clear of a set flag
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 async clear", trap_flag, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flag after second release", trap_flag, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule